// File: doc/BRIEF.md
# Stage-Based Temperature Estimator

This block turns a coarse over-temperature indication into a temperature figure in millidegrees Celsius. A thermal alarm reports a small stage number, 0 to 3, and the selected threshold bank is given as an index, 0 to 3. When a die-temperature converter is fitted, its reading is forwarded unchanged. When no converter is fitted, the block works out a figure from how the stage moves. A climb in stage reports the lowest temperature that could have caused it. A drop in stage reports the highest temperature that could remain. Each of these bounds is shifted by a hysteresis margin.

Software or a sequencer pulses `init_i` once to seed the estimate from the current stage. It then pulses `update_i` whenever the alarm signals that the stage changed. Each pulse produces one registered result on `temp_o`, qualified by a one-cycle `valid_o`.

Top module: `stage_temp_est`

## Requirements
- R1: After reset, `temp_o` is 0 and `valid_o` is 0. The stored stage is 0 and the stored estimate is 37000. An update with stage 0 straight after reset therefore reports 37000.
- R2: An init with `stage_i` = 0 and no converter present reports 37000.
- R3: An init with stage S > 0 and threshold T, with no converter present, reports 105000 + 5000*T + 20000*(S-1). No hysteresis is applied.
- R4: An update with no converter present, where S is above the stored stage, reports 105000 + 5000*T + 20000*(S-1) + 2000.
- R5: An update with no converter present, where S is below the stored stage, reports 105000 + 5000*T + 20000*S - 2000.
- R6: An update with no converter present, where S equals the stored stage, reports the previous estimate unchanged. This holds even if T has changed.
- R7: Every init, and every update with no converter present, replaces the stored stage with S. Nothing else changes the stored stage.
- R8: With `adc_present_i` = 1, an update reports `adc_i` and leaves the stored stage and the stored estimate untouched. An init still seeds them, but it reports `adc_i`.
- R9: A negative result is reported as 0. `adc_i` is a signed two's-complement value.
- R10: `valid_o` is 1 for exactly the one cycle that follows a cycle with `init_i` or `update_i` high. At all other times `valid_o` is 0 and `temp_o` holds its value.
- R11: When `init_i` and `update_i` are both high in the same cycle, the cycle behaves as an init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Seed estimate from current stage |
| update_i | input | 1 | Stage-change event |
| stage_i | input | 2 | Current over-temperature stage |
| thresh_i | input | 2 | Threshold bank index |
| adc_present_i | input | 1 | Converter reading is valid and takes priority |
| adc_i | input | 32 | Converter reading, signed millidegrees |
| temp_o | output | 32 | Reported temperature, millidegrees, never negative |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its default widths: a 2-bit stage, a 2-bit threshold index and a 32-bit result. At these widths every combination of threshold, seed stage and two following stages can be visited, which means every rising, falling and holding transition is checked from every starting point. Converter readings that are negative, zero and large, issued between stage updates, show that the bypass leaves the estimator state as it was.

// File: rtl/stage_temp_pkg.sv
package stage_temp_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_RISE = 2'd1,
    DIR_FALL = 2'd2
  } dir_e;
endpackage

// File: rtl/stage_tracker.sv
module stage_tracker
  import stage_temp_pkg::*;
#(
  parameter int STAGE_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STAGE_W-1:0] stage_i,
  output logic [STAGE_W-1:0] stage_o,
  output dir_e               dir_o
);
  logic [STAGE_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stage_q <= '0;
    else if (load_i) stage_q <= stage_i;
  end

  always_comb begin
    if (stage_i > stage_q)      dir_o = DIR_RISE;
    else if (stage_i < stage_q) dir_o = DIR_FALL;
    else                        dir_o = DIR_HOLD;
  end

  assign stage_o = stage_q;

  AST_STAGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(stage_q)); // R7
endmodule

// File: rtl/bound_calc.sv
module bound_calc
  import stage_temp_pkg::*;
#(
  parameter int STAGE_W     = 2,
  parameter int THR_W       = 2,
  parameter int TEMP_W      = 32,
  parameter int BASE_MC     = 105000,
  parameter int THR_STEP_MC = 5000,
  parameter int STG_STEP_MC = 20000,
  parameter int HYST_MC     = 2000,
  parameter int IDLE_MC     = 37000
) (
  input  logic                     init_i,
  input  dir_e                     dir_i,
  input  logic [STAGE_W-1:0]       stage_i,
  input  logic [THR_W-1:0]         thresh_i,
  input  logic signed [TEMP_W-1:0] est_q_i,
  output logic signed [TEMP_W-1:0] est_d_o
);
  localparam logic signed [TEMP_W-1:0] BASE = TEMP_W'(BASE_MC);
  localparam logic signed [TEMP_W-1:0] TSTP = TEMP_W'(THR_STEP_MC);
  localparam logic signed [TEMP_W-1:0] SSTP = TEMP_W'(STG_STEP_MC);
  localparam logic signed [TEMP_W-1:0] HYST = TEMP_W'(HYST_MC);
  localparam logic signed [TEMP_W-1:0] IDLE = TEMP_W'(IDLE_MC);

  logic signed [TEMP_W-1:0] s_v, t_v, floor_v, lo_v, hi_v, seed_v;

  always_comb begin
    s_v     = $signed(TEMP_W'(stage_i));
    t_v     = $signed(TEMP_W'(thresh_i));
    floor_v = BASE + TSTP * t_v;
    // lower edge of the new stage band
    lo_v    = floor_v + SSTP * (s_v - 1) + HYST;
    // upper edge of the new stage band
    hi_v    = floor_v + SSTP * s_v - HYST;
    seed_v  = (stage_i == '0) ? IDLE : floor_v + SSTP * (s_v - 1);
    if (init_i) est_d_o = seed_v;
    else begin
      unique case (dir_i)
        DIR_RISE: est_d_o = lo_v;
        DIR_FALL: est_d_o = hi_v;
        default:  est_d_o = est_q_i;
      endcase
    end
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int TEMP_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fire_i,
  input  logic                     bypass_i,
  input  logic signed [TEMP_W-1:0] adc_i,
  input  logic signed [TEMP_W-1:0] est_i,
  output logic [TEMP_W-1:0]        temp_o,
  output logic                     valid_o
);
  logic signed [TEMP_W-1:0] pick_v;

  always_comb begin
    pick_v = bypass_i ? adc_i : est_i;
    if (pick_v < 0) pick_v = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) temp_o <= pick_v;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> valid_o); // R10
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> !valid_o && $stable(temp_o)); // R10
  AST_NON_NEGATIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !temp_o[TEMP_W-1]); // R9
endmodule

// File: rtl/stage_temp_est.sv
module stage_temp_est
  import stage_temp_pkg::*;
#(
  parameter int STAGE_W     = 2,
  parameter int THR_W       = 2,
  parameter int TEMP_W      = 32,
  parameter int BASE_MC     = 105000,
  parameter int THR_STEP_MC = 5000,
  parameter int STG_STEP_MC = 20000,
  parameter int HYST_MC     = 2000,
  parameter int IDLE_MC     = 37000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic               update_i,
  input  logic [STAGE_W-1:0] stage_i,
  input  logic [THR_W-1:0]   thresh_i,
  input  logic               adc_present_i,
  input  logic [TEMP_W-1:0]  adc_i,
  output logic [TEMP_W-1:0]  temp_o,
  output logic               valid_o
);
  localparam int RISE_MIN = BASE_MC + HYST_MC;
  localparam int FALL_MAX = BASE_MC + THR_STEP_MC * (2**THR_W - 1)
                          + STG_STEP_MC * (2**STAGE_W - 2) - HYST_MC;

  logic                     load;
  logic                     fire;
  logic [STAGE_W-1:0]       stage_q;
  dir_e                     dir;
  logic signed [TEMP_W-1:0] est_q, est_d;

  assign fire = init_i | update_i;
  assign load = init_i | (update_i & ~adc_present_i);

  stage_tracker #(.STAGE_W(STAGE_W)) i_tracker (
    .clk_i, .rst_ni, .load_i(load), .stage_i, .stage_o(stage_q), .dir_o(dir)
  );

  bound_calc #(
    .STAGE_W(STAGE_W), .THR_W(THR_W), .TEMP_W(TEMP_W), .BASE_MC(BASE_MC),
    .THR_STEP_MC(THR_STEP_MC), .STG_STEP_MC(STG_STEP_MC),
    .HYST_MC(HYST_MC), .IDLE_MC(IDLE_MC)
  ) i_bounds (
    .init_i, .dir_i(dir), .stage_i, .thresh_i, .est_q_i(est_q), .est_d_o(est_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   est_q <= TEMP_W'(IDLE_MC);
    else if (load) est_q <= est_d;
  end

  out_stage #(.TEMP_W(TEMP_W)) i_out (
    .clk_i, .rst_ni, .fire_i(fire), .bypass_i(adc_present_i),
    .adc_i($signed(adc_i)), .est_i(est_d), .temp_o, .valid_o
  );

  AST_HOLD_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !init_i && !adc_present_i && stage_i == stage_q) |=> $stable(est_q)); // R6
  AST_RISE_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !init_i && !adc_present_i && stage_i > stage_q)
      |=> est_q >= TEMP_W'(RISE_MIN)); // R4
  AST_FALL_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !init_i && !adc_present_i && stage_i < stage_q)
      |=> est_q <= TEMP_W'(FALL_MAX)); // R5
  AST_BYPASS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !init_i && adc_present_i) |=> $stable(est_q) && $stable(stage_q)); // R8
  AST_SEED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && stage_i == '0) |=> est_q == TEMP_W'(IDLE_MC)); // R2
endmodule

// File: tb/test_stage_temp_est.sv
`timescale 1ns/1ps
module test_stage_temp_est;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_s = 1'b0, upd_s = 1'b0, ap_s = 1'b0;
  logic [1:0]  stage_s = '0, thr_s = '0;
  logic [31:0] adc_s = '0;
  logic [31:0] temp;
  logic        valid;

  int total = 0, bad = 0;
  int m_stage = 0, m_est = 37000;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stage_temp_est i_stage_temp_est (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init_s), .update_i(upd_s),
    .stage_i(stage_s), .thresh_i(thr_s), .adc_present_i(ap_s), .adc_i(adc_s),
    .temp_o(temp), .valid_o(valid)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobe, then check result and the idle cycle after it
  task automatic op(bit ini, bit upd, int s, int t, bit ap, int av, string req);
    int exp_v;
    int prev;
    @(negedge clk);
    init_s = ini; upd_s = upd; stage_s = 2'(s); thr_s = 2'(t);
    ap_s = ap; adc_s = av;
    if (ini) begin
      m_stage = s;
      m_est = (s == 0) ? 37000 : 105000 + 5000*t + 20000*(s-1);
    end else if (!ap) begin
      if (s > m_stage)      m_est = 105000 + 5000*t + 20000*(s-1) + 2000;
      else if (s < m_stage) m_est = 105000 + 5000*t + 20000*s - 2000;
      m_stage = s;
    end
    exp_v = ap ? av : m_est;
    if (exp_v < 0) exp_v = 0;
    @(negedge clk);
    init_s = 1'b0; upd_s = 1'b0;
    check({req, " value"}, int'(temp), exp_v);
    check("R10 valid high", int'(valid), 1);
    prev = int'(temp);
    @(negedge clk);
    check("R10 valid low", int'(valid), 0);
    check("R10 hold", int'(temp), prev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset temp", int'(temp), 0);
    check("R1 reset valid", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle temp", int'(temp), 0);
    op(0, 1, 0, 2, 0, 0, "R1 first update same stage");
    op(0, 1, 1, 2, 0, 0, "R4 rise from reset");

    for (int t = 0; t < 4; t++)
      for (int s0 = 0; s0 < 4; s0++)
        for (int s1 = 0; s1 < 4; s1++) begin
          op(1, 0, s0, t, 0, 0, s0 == 0 ? "R2 init idle" : "R3 init seed");
          op(0, 1, s1, t, 0, 0, s1 > s0 ? "R4 rise" : (s1 < s0 ? "R5 fall" : "R6 same"));
          for (int s2 = 0; s2 < 4; s2++)
            op(0, 1, s2, (t + s2) % 4, 0, 0, "R7 chained stage");
        end

    op(1, 0, 2, 1, 0, 0, "R3 seed before bypass");
    op(0, 1, 3, 1, 1, 98765, "R8 bypass positive");
    op(0, 1, 0, 1, 1, -5000, "R9 bypass negative clamp");
    op(0, 1, 1, 1, 1, 0, "R8 bypass zero");
    op(0, 1, 2, 3, 0, 0, "R8 state kept, same stage holds");
    op(0, 1, 3, 0, 0, 0, "R8 state kept, rise");
    op(1, 0, 1, 0, 1, 123456, "R8 init with converter");
    op(0, 1, 2, 0, 0, 0, "R8 init seeded stage then rise");
    op(1, 0, 3, 2, 1, -1, "R9 init clamp");
    op(0, 1, 3, 2, 0, 0, "R6 after clamped init");
    op(1, 1, 0, 3, 0, 0, "R11 init wins");
    op(1, 1, 2, 3, 0, 0, "R11 init wins nonzero");
    op(0, 1, 1, 3, 0, 0, "R5 after dual strobe");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule